// File: doc/BRIEF.md
# One-Pass Fractional Pixel Interpolator

This block builds every half-pixel and quarter-pixel candidate for one 4x4 block around an integer motion-search winner. It reads each integer reference patch once. From the registered patch it emits all 48 fractional candidates on consecutive cycles. Each candidate is tagged with its fractional offset in quarter-pixel units and with the index of the refined mode it belongs to.

Half-pixel samples are filtered from integer samples. Each quarter-pixel sample is the rounded mean of two samples on the half-pixel grid, never a fresh filter of integer pixels. So one fetched patch serves both refinement levels, with no second read.

A job starts with a refinement count from 0 to 7. That count is the number of best modes that integer search kept. For every mode the block asks for one patch and streams that patch's candidates. A count of zero finishes the job at once.

Top module: `fpi_onepass`

## Requirements
- R1: After reset, `out_valid`, `done` and `patch_rdy` are low.
- R2: A `start` pulse in idle with `mode_cnt` = 0 produces no candidate. It raises `done` for one cycle on the next clock, and `patch_rdy` stays low.
- R3: A `start` pulse in idle with `mode_cnt` = N (1..7) opens N patch slots.
  - In each slot, `patch_rdy` stays high until `patch_vld` is sampled high.
  - The accepted patch then yields 48 candidates on consecutive cycles.
  - The order is `out_fy` as the outer loop from -3 to 3 and `out_fx` as the inner loop from -3 to 3.
  - The offset pair (0,0) is skipped.
- R4: Layout of `patch`: it is a 10x10 grid of 8-bit pixels, with pixel (r,c) at bits [(r*10+c)*8 +: 8].
  - The block's integer pixel (i,j) sits at patch (i+3, j+3).
  - Output pixel (i,j) is at `out_pix` bits [(i*4+j)*8 +: 8].
- R5: Grid points and one-axis half samples.
  - A grid sample at even quarter offsets (ex,ey) in -4..4 has a per-axis integer shift: -1 for -4 and -2, 0 for 0 and 2, and +1 for 4.
  - An axis whose offset is ±2 is a half position lying between the shifted pixel and its right (or lower) neighbour.
  - A one-axis half sample applies taps (1,-5,20,20,-5,1) starting two pixels before the shifted pixel. The sum then has 16 added, is shifted arithmetically right by 5, and is clipped to 0..255.
- R6: A sample that is half on both axes applies the vertical 6-tap filter to the unrounded horizontal sums of six rows. The result has 512 added, is shifted arithmetically right by 10, and is clipped to 0..255.
- R7: The candidate at (qx,qy) is (A+B+1)>>1.
  - A is the grid sample at (qx-ox, qy-oy) and B is the grid sample at (qx+ox, qy+oy).
  - ox is 1 when qx is odd and 0 otherwise, and oy is defined the same way from qy.
  - When both offsets are even, A equals B.
- R8: Tags on each output.
  - `out_fx` and `out_fy` are 3-bit two's complement quarter-pixel offsets.
  - `out_mode` is the slot index, from 0 to N-1.
  - `out_last` is high only on the 48th candidate of a slot, which is offset (3,3).
- R9: `start` is ignored while a job is in progress, so the job's output count and slot count are unchanged.
- R10: At the end of an N>0 job, `done` is high in the same cycle as the final candidate of the last slot, and high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (sampled only when idle) |
| mode_cnt | input | 3 | Number of modes to refine, 0..7 |
| patch_rdy | output | 1 | Waiting for the next integer patch |
| patch_vld | input | 1 | Patch presented on `patch` |
| patch | input | 800 | 10x10 integer reference patch, 8 bits per pixel |
| out_valid | output | 1 | Candidate block valid |
| out_fx | output | 3 | Horizontal fractional offset, quarter units, signed |
| out_fy | output | 3 | Vertical fractional offset, quarter units, signed |
| out_mode | output | 3 | Mode slot index of the candidate |
| out_last | output | 1 | Final candidate of the slot |
| out_pix | output | 128 | 4x4 candidate pixels, 8 bits each |
| done | output | 1 | Job finished pulse |

## Verification
The candidate offset counters could skip or repeat a step. That shows at once as a tag mismatch on the very next candidate, and it shifts every later comparison in the slot. A stale or wrongly loaded patch register corrupts every pixel of the first candidate after the load. A wrong slot counter shows at the end of a slot: `out_mode` is wrong, or `done` fires on the wrong candidate, or `patch_rdy` rises once too many or too few times.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } fpi_state_e;

    // six-tap half-sample kernel, unrounded
    function automatic int fpi_tap6(input int a, input int b, input int c,
                                    input int d, input int e, input int f);
        return a - 5 * b + 20 * c + 20 * d - 5 * e + f;
    endfunction

    function automatic int fpi_clip(input int v, input int maxv);
        if (v < 0)
            return 0;
        else if (v > maxv)
            return maxv;
        else
            return v;
    endfunction

endpackage

// File: rtl/fpi_qpel_pix.sv
module fpi_qpel_pix
    import fpi_pkg::*;
#(
    parameter int BLK   = 4,
    parameter int PIX_W = 8,
    parameter int ROW   = 0,
    parameter int COL   = 0,
    localparam int PATCH = BLK + 6,
    localparam int PBITS = PATCH * PATCH * PIX_W
) (
    input  logic [PBITS-1:0]  patch,
    input  logic signed [2:0] qx,
    input  logic signed [2:0] qy,
    output logic [PIX_W-1:0]  pix
);
    localparam int OFF  = 3;
    localparam int MAXV = (1 << PIX_W) - 1;

    function automatic int px(input logic [PBITS-1:0] p, input int r, input int c);
        return int'(p[(r * PATCH + c) * PIX_W +: PIX_W]);
    endfunction

    // horizontal raw sum for the half position right of column c
    function automatic int hsum(input logic [PBITS-1:0] p, input int r, input int c);
        return fpi_tap6(px(p, r, c - 2), px(p, r, c - 1), px(p, r, c),
                        px(p, r, c + 1), px(p, r, c + 2), px(p, r, c + 3));
    endfunction

    // sample of the half-pixel grid at even quarter offsets (ex, ey)
    function automatic int grid(input logic [PBITS-1:0] p, input int ex, input int ey);
        int r;
        int c;
        int acc;
        int t [6];
        logic hx;
        logic hy;
        c  = OFF + COL + (ex >>> 2);
        r  = OFF + ROW + (ey >>> 2);
        hx = ((ex & 3) == 2);
        hy = ((ey & 3) == 2);
        if (hx && hy) begin
            for (int k = 0; k < 6; k++)
                t[k] = hsum(p, r - 2 + k, c);
            acc = fpi_tap6(t[0], t[1], t[2], t[3], t[4], t[5]);
            return fpi_clip((acc + 512) >>> 10, MAXV);
        end else if (hx) begin
            return fpi_clip((hsum(p, r, c) + 16) >>> 5, MAXV);
        end else if (hy) begin
            acc = fpi_tap6(px(p, r - 2, c), px(p, r - 1, c), px(p, r, c),
                           px(p, r + 1, c), px(p, r + 2, c), px(p, r + 3, c));
            return fpi_clip((acc + 16) >>> 5, MAXV);
        end else begin
            return px(p, r, c);
        end
    endfunction

    int qxi;
    int qyi;
    int ox;
    int oy;
    int a_s;
    int b_s;

    always_comb begin
        qxi = int'(qx);
        qyi = int'(qy);
        ox  = qxi & 1;
        oy  = qyi & 1;
        a_s = grid(patch, qxi - ox, qyi - oy);
        b_s = grid(patch, qxi + ox, qyi + oy);
        pix = PIX_W'((a_s + b_s + 1) >>> 1);
    end

    // R5: every grid sample lands inside the pixel range
    always_comb begin
        assert_grid_range_R5: assert (a_s >= 0 && a_s <= MAXV && b_s >= 0 && b_s <= MAXV);
    end

    // R7: the quarter sample lies between its two grid samples
    always_comb begin
        assert_avg_bounded_R7: assert (int'(pix) >= ((a_s < b_s) ? a_s : b_s) &&
                                       int'(pix) <= ((a_s > b_s) ? a_s : b_s));
    end

endmodule

// File: rtl/fpi_seq.sv
module fpi_seq
    import fpi_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_cnt,
    input  logic              patch_vld,
    output logic              patch_rdy,
    output logic              load,
    output logic              run,
    output logic signed [2:0] qx,
    output logic signed [2:0] qy,
    output logic [MODE_W-1:0] mode_idx,
    output logic              last,
    output logic              done
);
    typedef struct packed {
        fpi_state_e        st;
        logic [MODE_W-1:0] cnt;
        logic [MODE_W-1:0] mode;
        logic signed [2:0] qx;
        logic signed [2:0] qy;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic signed [2:0] nx_d, ny_d;

    always_comb begin
        seq_d = seq_q;
        seq_d.done = 1'b0;
        load = 1'b0;
        nx_d = seq_q.qx + 3'sd1;
        ny_d = seq_q.qy;
        if (seq_q.qx == 3'sd3) begin
            nx_d = -3'sd3;
            ny_d = seq_q.qy + 3'sd1;
        end
        if (nx_d == 3'sd0 && ny_d == 3'sd0)
            nx_d = 3'sd1;
        last = (seq_q.st == ST_RUN) && (seq_q.qx == 3'sd3) && (seq_q.qy == 3'sd3);
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (mode_cnt == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.cnt  = mode_cnt;
                        seq_d.mode = '0;
                        seq_d.st   = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (patch_vld) begin
                    load     = 1'b1;
                    seq_d.st = ST_RUN;
                    seq_d.qx = -3'sd3;
                    seq_d.qy = -3'sd3;
                end
            end
            ST_RUN: begin
                if (last) begin
                    if (seq_q.mode == seq_q.cnt - MODE_W'(1)) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.mode = seq_q.mode + MODE_W'(1);
                        seq_d.st   = ST_WAIT;
                    end
                end else begin
                    seq_d.qx = nx_d;
                    seq_d.qy = ny_d;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_q <= '0;
        else
            seq_q <= seq_d;
    end

    assign patch_rdy = (seq_q.st == ST_WAIT);
    assign run       = (seq_q.st == ST_RUN);
    assign qx        = seq_q.qx;
    assign qy        = seq_q.qy;
    assign mode_idx  = seq_q.mode;
    assign done      = seq_q.done;

    // R2: an empty job finishes on the next clock without asking for a patch
    assert_zero_job_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !patch_rdy && start && mode_cnt == '0) |=> (done && !patch_rdy));

    // R3: a slot streams without gaps until its final candidate
    assert_run_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> run);

    // R8: slot index stays below the requested count
    assert_mode_below_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run || patch_rdy) |-> (mode_idx < seq_q.cnt));

endmodule

// File: rtl/fpi_onepass.sv
module fpi_onepass
    import fpi_pkg::*;
#(
    parameter int BLK    = 4,
    parameter int PIX_W  = 8,
    parameter int MODE_W = 3,
    localparam int PATCH = BLK + 6,
    localparam int PBITS = PATCH * PATCH * PIX_W,
    localparam int BBITS = BLK * BLK * PIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_cnt,
    output logic              patch_rdy,
    input  logic              patch_vld,
    input  logic [PBITS-1:0]  patch,
    output logic              out_valid,
    output logic signed [2:0] out_fx,
    output logic signed [2:0] out_fy,
    output logic [MODE_W-1:0] out_mode,
    output logic              out_last,
    output logic [BBITS-1:0]  out_pix,
    output logic              done
);
    typedef struct packed {
        logic [PBITS-1:0]  patch;
        logic              vld;
        logic signed [2:0] fx;
        logic signed [2:0] fy;
        logic [MODE_W-1:0] mode;
        logic              last;
        logic [BBITS-1:0]  pix;
    } top_t;

    top_t top_d, top_q;

    logic              load_w, run_w, last_w;
    logic signed [2:0] qx_w, qy_w;
    logic [MODE_W-1:0] mode_w;
    logic [BBITS-1:0]  pix_w;

    fpi_seq #(.MODE_W(MODE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode_cnt (mode_cnt),
        .patch_vld(patch_vld),
        .patch_rdy(patch_rdy),
        .load     (load_w),
        .run      (run_w),
        .qx       (qx_w),
        .qy       (qy_w),
        .mode_idx (mode_w),
        .last     (last_w),
        .done     (done)
    );

    for (genvar gi = 0; gi < BLK; gi++) begin : g_row
        for (genvar gj = 0; gj < BLK; gj++) begin : g_col
            fpi_qpel_pix #(.BLK(BLK), .PIX_W(PIX_W), .ROW(gi), .COL(gj)) u_pix (
                .patch(top_q.patch),
                .qx   (qx_w),
                .qy   (qy_w),
                .pix  (pix_w[(gi * BLK + gj) * PIX_W +: PIX_W])
            );
        end
    end

    always_comb begin
        top_d = top_q;
        top_d.vld = run_w;
        if (load_w)
            top_d.patch = patch;
        if (run_w) begin
            top_d.fx   = qx_w;
            top_d.fy   = qy_w;
            top_d.mode = mode_w;
            top_d.last = last_w;
            top_d.pix  = pix_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            top_q <= '0;
        else
            top_q <= top_d;
    end

    assign out_valid = top_q.vld;
    assign out_fx    = top_q.fx;
    assign out_fy    = top_q.fy;
    assign out_mode  = top_q.mode;
    assign out_last  = top_q.last;
    assign out_pix   = top_q.pix;

    // R3: the integer position never appears as a candidate
    assert_no_center_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_fx == 3'sd0 && out_fy == 3'sd0));

    // R8: the slot-final flag marks offset (3,3)
    assert_last_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_fx == 3'sd3 && out_fy == 3'sd3));

    // R10: a finish pulse alongside output only on the final candidate
    assert_done_with_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid || out_last));

endmodule

// File: tb/fpi_onepass_tb.sv
`timescale 1ns/1ps
module fpi_onepass_tb;
    localparam int BLK = 4;
    localparam int PATCH = BLK + 6;
    localparam int PBITS = PATCH * PATCH * 8;
    localparam int BBITS = BLK * BLK * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode_cnt = '0;
    logic patch_rdy;
    logic patch_vld = 1'b0;
    logic [PBITS-1:0] patch = '0;
    logic out_valid;
    logic signed [2:0] out_fx, out_fy;
    logic [2:0] out_mode;
    logic out_last;
    logic [BBITS-1:0] out_pix;
    logic done;

    always #10 clk = ~clk;

    fpi_onepass u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_cnt(mode_cnt),
        .patch_rdy(patch_rdy), .patch_vld(patch_vld), .patch(patch),
        .out_valid(out_valid), .out_fx(out_fx), .out_fy(out_fy),
        .out_mode(out_mode), .out_last(out_last), .out_pix(out_pix), .done(done)
    );

    typedef struct {
        int fx;
        int fy;
        int mode;
        bit last;
        bit fin;
        logic [BBITS-1:0] pix;
    } exp_t;

    exp_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    int done_seen = 0;
    bit bare_ok = 0;
    int pat_no = 0;
    int mp [PATCH][PATCH];

    task automatic chk(input bit ok, input string tag, input logic [BBITS-1:0] act,
                       input logic [BBITS-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int m_clip(input int v);
        return (v < 0) ? 0 : ((v > 255) ? 255 : v);
    endfunction

    function automatic int m_k(input int a, input int b, input int c,
                               input int d, input int e, input int f);
        return (a + f) - 5 * (b + e) + 20 * (c + d);
    endfunction

    function automatic int m_hraw(input int r, input int c);
        return m_k(mp[r][c-2], mp[r][c-1], mp[r][c], mp[r][c+1], mp[r][c+2], mp[r][c+3]);
    endfunction

    function automatic int m_grid(input int ex, input int ey, input int i, input int j);
        int sx, sy, r, c, v;
        int t [6];
        bit hx, hy;
        sx = (ex < 0) ? -1 : ((ex == 4) ? 1 : 0);
        sy = (ey < 0) ? -1 : ((ey == 4) ? 1 : 0);
        hx = (ex == 2 || ex == -2);
        hy = (ey == 2 || ey == -2);
        r = i + 3 + sy;
        c = j + 3 + sx;
        if (hx && hy) begin
            for (int k = 0; k < 6; k++) t[k] = m_hraw(r - 2 + k, c);
            v = m_k(t[0], t[1], t[2], t[3], t[4], t[5]);
            return m_clip((v + 512) >>> 10);
        end
        if (hx) return m_clip((m_hraw(r, c) + 16) >>> 5);
        if (hy) begin
            v = m_k(mp[r-2][c], mp[r-1][c], mp[r][c], mp[r+1][c], mp[r+2][c], mp[r+3][c]);
            return m_clip((v + 16) >>> 5);
        end
        return mp[r][c];
    endfunction

    function automatic logic [BBITS-1:0] m_cand(input int qx, input int qy);
        logic [BBITS-1:0] res;
        int ox, oy, a, b;
        ox = (qx % 2 != 0) ? 1 : 0;
        oy = (qy % 2 != 0) ? 1 : 0;
        for (int i = 0; i < BLK; i++)
            for (int j = 0; j < BLK; j++) begin
                a = m_grid(qx - ox, qy - oy, i, j);
                b = m_grid(qx + ox, qy + oy, i, j);
                res[(i * BLK + j) * 8 +: 8] = 8'((a + b + 1) / 2);
            end
        return res;
    endfunction

    task automatic fill_patch(input int kind);
        for (int r = 0; r < PATCH; r++)
            for (int c = 0; c < PATCH; c++) begin
                case (kind)
                    0: mp[r][c] = 0;
                    1: mp[r][c] = 255;
                    2: mp[r][c] = ((r + c) % 2 != 0) ? 255 : 0;
                    3: mp[r][c] = (c % 3 == 0) ? 255 : 10;
                    default: mp[r][c] = int'($urandom_range(255, 0));
                endcase
                patch[(r * PATCH + c) * 8 +: 8] = 8'(mp[r][c]);
            end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_seen++;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R3 unexpected candidate", BBITS'(out_fx), '0);
                end else begin
                    exp_t e;
                    string ptag;
                    e = sb.pop_front();
                    chk(int'(out_fx) == e.fx && int'(out_fy) == e.fy, "R3 offset order",
                        BBITS'({out_fy, out_fx}), BBITS'({3'(e.fy), 3'(e.fx)}));
                    chk(int'(out_mode) == e.mode && out_last == e.last, "R8 mode/last tag",
                        BBITS'({out_mode, out_last}), BBITS'({3'(e.mode), e.last}));
                    if (e.fx % 2 != 0 || e.fy % 2 != 0) ptag = "R7 quarter pixels";
                    else if (e.fx != 0 && e.fy != 0) ptag = "R6 diagonal half pixels";
                    else ptag = "R5 R4 half pixels";
                    chk(out_pix == e.pix, ptag, out_pix, e.pix);
                    chk(done == e.fin, "R10 done alignment", BBITS'(done), BBITS'(e.fin));
                end
            end else if (done && !bare_ok) begin
                chk(0, "R10 stray done", 1, 0);
            end
        end
    end

    task automatic run_job(input int n, input bit poke);
        int d0;
        d0 = done_seen;
        @(negedge clk);
        start = 1'b1;
        mode_cnt = 3'(n);
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < n; m++) begin
            int guard = 0;
            while (!patch_rdy && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            chk(patch_rdy, "R3 patch slot requested", BBITS'(patch_rdy), 1);
            fill_patch(pat_no);
            pat_no++;
            for (int qy = -3; qy <= 3; qy++)
                for (int qx = -3; qx <= 3; qx++)
                    if (qx != 0 || qy != 0) begin
                        exp_t e;
                        e.fx = qx; e.fy = qy; e.mode = m;
                        e.last = (qx == 3 && qy == 3);
                        e.fin = e.last && (m == n - 1);
                        e.pix = m_cand(qx, qy);
                        sb.push_back(e);
                    end
            patch_vld = 1'b1;
            @(negedge clk);
            patch_vld = 1'b0;
            if (poke && m == 0) begin
                repeat (5) @(negedge clk);
                start = 1'b1;   // R9: ignored while busy
                mode_cnt = 3'd5;
                @(negedge clk);
                start = 1'b0;
            end
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done_seen == d0 + 1, "R10 one done per job", BBITS'(done_seen - d0), 1);
        chk(!patch_rdy && !out_valid, "R9 no extra slot after job",
            BBITS'({patch_rdy, out_valid}), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !done && !patch_rdy, "R1 reset state",
            BBITS'({out_valid, done, patch_rdy}), 0);
        // R2: empty job
        bare_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        mode_cnt = 3'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done && !out_valid, "R2 immediate done", BBITS'({done, out_valid}), 2);
        @(negedge clk);
        chk(!patch_rdy && !done, "R2 no patch requested", BBITS'({patch_rdy, done}), 0);
        bare_ok = 1'b0;
        run_job(1, 1'b0);
        run_job(3, 1'b1);
        run_job(7, 1'b0);
        run_job(2, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule